// File: doc/BRIEF.md
# Linked Descriptor Write-Immediate Sequencer

This block follows a chain of descriptors stored in memory and carries out each one in turn. Software gives a first descriptor address and a start pulse. The block then fetches the four 32-bit words of that descriptor through a single read port, one word per accepted read. It decodes the type field of the control word and runs the descriptor. It reads the link word to decide whether to fetch another descriptor and where that descriptor is.

Two descriptor kinds run. A store descriptor writes one 32-bit immediate value to a 32-bit address. A chain can use it to patch a register, or a later descriptor, partway through the sequence. A wait descriptor holds the chain until a masked compare against an external trigger vector succeeds. Each descriptor can ask for an interrupt pulse when it completes. A busy output covers the whole run. The run ends with a done pulse, or with an error pulse when a descriptor is illegal.

Descriptor layout, as offsets from the descriptor address:

- +0: control word. Bits [1:0] hold the type. Bit 20 is the interrupt request.
- +4: the immediate value, or the wait fields.
- +8: the store address.
- +12: the link word.

Top module: `ldchain_seq`

## Requirements
- R1: A descriptor whose control bits [1:0] equal 2 makes exactly one store. The store writes word +4 to the address held in word +8, and then the descriptor completes.
- R2: A store descriptor reached directly from start_i makes no store. It gives a one-cycle err_o pulse with busy_o low, and it gives no done_o pulse.
- R3: When a descriptor with control bit 20 set completes, irq_o pulses high for exactly one cycle.
- R4: A descriptor of type 1 holds the chain until (sync_trig_i & EN) == (MV & EN). MV is word +4 bits [SYNC_W-1:0] and EN is word +4 bits [16+SYNC_W-1:16]. Trigger bits where EN is 0 have no effect, and an EN of all zeros passes at once.
- R5: The wait compare is evaluated in every cycle of the wait, so a trigger pattern present for a single cycle releases the chain.
- R6: In the link word, bit 0 enables the next fetch, bit 1 selects the mode, and bits [31:2] followed by two zero bits form a value. Mode 0 uses that value as the next absolute address. Mode 1 adds it, as a signed offset, to the current descriptor's address.
- R7: When the link enable bit of a completed descriptor is 0, done_o pulses for one cycle and busy_o is low in that same cycle.
- R8: Each descriptor is read as four words at addresses +0, +4, +8 and +12 in that order. rd_req_o and rd_addr_o hold steady until rd_valid_i accepts the word. A read request and a store request never overlap.
- R9: A descriptor whose type is 0 or 3 makes no store and ends the chain with an err_o pulse.
- R10: busy_o rises after start_i and stays high until the chain ends. A start_i while busy_o is high is ignored.
- R11: wr_req_o, wr_addr_o and wr_data_o hold steady until wr_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a chain when idle |
| start_addr_i | input | 32 | Address of the first descriptor |
| sync_trig_i | input | SYNC_W | External trigger vector |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | 32 | Read address |
| rd_valid_i | input | 1 | Read data valid, word accepted |
| rd_data_i | input | 32 | Read data |
| wr_req_o | output | 1 | Store request |
| wr_addr_o | output | 32 | Store address |
| wr_data_o | output | 32 | Store data |
| wr_ack_i | input | 1 | Store accepted |
| busy_o | output | 1 | Chain in progress |
| irq_o | output | 1 | Descriptor-complete interrupt pulse |
| done_o | output | 1 | Chain-finished pulse |
| err_o | output | 1 | Illegal-descriptor pulse |

## Verification
The bench uses the default parameters: an 8-bit trigger vector, with the match value in bits [7:0] of word +4 and the enable mask in bits [23:16]. This width lets a trigger differ from the match value in bits outside a 4-bit mask while still matching inside it, so mask handling is tested. The memory model in the bench answers reads and stores with irregular stall patterns, so the hold rules on both handshakes are tested. One chain uses a store to rewrite the link word of a later descriptor before that descriptor is fetched. Another chain uses both a forward and a backward relative link.

// File: rtl/ldchain_pkg.sv
package ldchain_pkg;

  localparam int DESC_WORDS = 4;
  localparam int W_CTRL     = 0;
  localparam int W_VAL      = 1;
  localparam int W_DST      = 2;
  localparam int W_LINK     = 3;
  localparam int IRQ_BIT    = 20;

  typedef enum logic [1:0] {
    DT_NONE = 2'd0,
    DT_SYNC = 2'd1,
    DT_WRI  = 2'd2,
    DT_RSVD = 2'd3
  } desc_type_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_STORE,
    ST_WAIT
  } seq_state_e;

  function automatic desc_type_e desc_type(input logic [31:0] ctrl);
    return desc_type_e'(ctrl[1:0]);
  endfunction

  function automatic logic done_irq(input logic [31:0] ctrl);
    return ctrl[IRQ_BIT];
  endfunction

  function automatic logic link_on(input logic [31:0] lw);
    return lw[0];
  endfunction

  // Next descriptor address: absolute, or signed offset from the current base.
  function automatic logic [31:0] link_target(input logic [31:0] base,
                                              input logic [31:0] lw);
    logic [31:0] field;
    field = {lw[31:2], 2'b00};
    return lw[1] ? (base + field) : field;
  endfunction

  // Masked equality, 16 bits wide; narrower users zero-extend.
  function automatic logic masked_eq(input logic [15:0] trig,
                                     input logic [15:0] val,
                                     input logic [15:0] en);
    return ((trig ^ val) & en) == 16'h0000;
  endfunction

endpackage

// File: rtl/ldchain_fetch.sv
module ldchain_fetch
  import ldchain_pkg::*;
#(
  parameter int WORDS = DESC_WORDS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic                   active_i,
  input  logic [31:0]            base_i,
  input  logic                   rd_valid_i,
  input  logic [31:0]            rd_data_i,
  output logic                   rd_req_o,
  output logic [31:0]            rd_addr_o,
  output logic                   last_o,
  output logic [WORDS-1:0][31:0] words_o
);

  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [IW-1:0] idx_q;
  logic          beat;

  assign rd_req_o  = active_i;
  assign beat      = active_i && rd_valid_i;
  assign rd_addr_o = base_i + (32'(idx_q) << 2);
  assign last_o    = beat && (idx_q == IW'(WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= '0;
    else if (load_i)   idx_q <= '0;
    else if (beat)     idx_q <= (idx_q == IW'(WORDS - 1)) ? '0 : idx_q + 1'b1;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           words_o[w] <= '0;
      else if (beat && idx_q == IW'(w))     words_o[w] <= rd_data_i;
    end
  end

endmodule

// File: rtl/ldchain_sync_cmp.sv
module ldchain_sync_cmp
  import ldchain_pkg::*;
#(
  parameter int SYNC_W     = 8,
  parameter int MATCH_LSB  = 0,
  parameter int ENABLE_LSB = 16
) (
  input  logic [SYNC_W-1:0] trig_i,
  input  logic [31:0]       word_i,
  output logic              hit_o
);

  logic [15:0] trig_x, val_x, en_x;

  assign trig_x = 16'(trig_i);
  assign val_x  = 16'(word_i[MATCH_LSB +: SYNC_W]);
  assign en_x   = 16'(word_i[ENABLE_LSB +: SYNC_W]);
  assign hit_o  = masked_eq(trig_x, val_x, en_x);

endmodule

// File: rtl/ldchain_link_calc.sv
module ldchain_link_calc
  import ldchain_pkg::*;
(
  input  logic [31:0] base_i,
  input  logic [31:0] link_i,
  output logic        enable_o,
  output logic [31:0] next_o
);

  assign enable_o = link_on(link_i);
  assign next_o   = link_target(base_i, link_i);

endmodule

// File: rtl/ldchain_seq.sv
module ldchain_seq
  import ldchain_pkg::*;
#(
  parameter int SYNC_W     = 8,
  parameter int MATCH_LSB  = 0,
  parameter int ENABLE_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       start_addr_i,
  input  logic [SYNC_W-1:0] sync_trig_i,
  output logic              rd_req_o,
  output logic [31:0]       rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [31:0]       rd_data_i,
  output logic              wr_req_o,
  output logic [31:0]       wr_addr_o,
  output logic [31:0]       wr_data_o,
  input  logic              wr_ack_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic              done_o,
  output logic              err_o
);

  seq_state_e state_q;
  logic [31:0] base_q;
  logic        first_q;
  logic        irq_q, done_q, err_q;

  logic [DESC_WORDS-1:0][31:0] words;
  logic        last_beat;
  logic        fetch_active;
  logic        fetch_load;
  logic        sync_wait;
  logic        sync_hit;
  logic        desc_done;
  logic        lnk_en;
  logic [31:0] lnk_next;
  desc_type_e  cur_type;

  assign fetch_active = (state_q == ST_FETCH);
  assign sync_wait    = (state_q == ST_WAIT);
  assign wr_req_o     = (state_q == ST_STORE);
  assign busy_o       = (state_q != ST_IDLE);
  assign cur_type     = desc_type(words[W_CTRL]);
  assign desc_done    = (wr_req_o && wr_ack_i) || (sync_wait && sync_hit);
  assign fetch_load   = ((state_q == ST_IDLE) && start_i) || (desc_done && lnk_en);

  assign wr_addr_o = words[W_DST];
  assign wr_data_o = words[W_VAL];
  assign irq_o     = irq_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  ldchain_fetch #(.WORDS(DESC_WORDS)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (fetch_load),
    .active_i   (fetch_active),
    .base_i     (base_q),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .last_o     (last_beat),
    .words_o    (words)
  );

  ldchain_sync_cmp #(
    .SYNC_W     (SYNC_W),
    .MATCH_LSB  (MATCH_LSB),
    .ENABLE_LSB (ENABLE_LSB)
  ) u_sync (
    .trig_i (sync_trig_i),
    .word_i (words[W_VAL]),
    .hit_o  (sync_hit)
  );

  ldchain_link_calc u_link (
    .base_i   (base_q),
    .link_i   (words[W_LINK]),
    .enable_o (lnk_en),
    .next_o   (lnk_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      first_q <= 1'b0;
      irq_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      irq_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            base_q  <= start_addr_i;
            first_q <= 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (last_beat) begin
            unique case (cur_type)
              DT_SYNC: state_q <= ST_WAIT;
              DT_WRI: begin
                if (first_q) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
                end else begin
                  state_q <= ST_STORE;
                end
              end
              default: begin
                err_q   <= 1'b1;
                state_q <= ST_IDLE;
              end
            endcase
          end
        end
        ST_STORE, ST_WAIT: begin
          if (desc_done) begin
            irq_q <= done_irq(words[W_CTRL]);
            if (lnk_en) begin
              base_q  <= lnk_next;
              first_q <= 1'b0;
              state_q <= ST_FETCH;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ldchain_seq_chk.sv
module ldchain_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        irq_o,
  input logic        done_o,
  input logic        err_o,
  input logic        rd_req_o,
  input logic        rd_valid_i,
  input logic [31:0] rd_addr_o,
  input logic        wr_req_o,
  input logic        wr_ack_i,
  input logic [31:0] wr_addr_o,
  input logic [31:0] wr_data_o,
  input logic        sync_wait,
  input logic        sync_hit
);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R8
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_req_o));

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !done_o));

  // R4
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_wait && !sync_hit) |=> (sync_wait && !rd_req_o && !done_o));

  // R10
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !busy_o);

endmodule

bind ldchain_seq ldchain_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .irq_o      (irq_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .rd_req_o   (rd_req_o),
  .rd_valid_i (rd_valid_i),
  .rd_addr_o  (rd_addr_o),
  .wr_req_o   (wr_req_o),
  .wr_ack_i   (wr_ack_i),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .sync_wait  (sync_wait),
  .sync_hit   (sync_hit)
);

// File: tb/ldchain_seq_test.sv
module ldchain_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;

  typedef struct packed {
    logic [31:0] start;
    logic [7:0]  n_irq;
    logic [7:0]  n_done;
    logic [7:0]  n_err;
    logic [7:0]  n_rd;
    logic [7:0]  n_wr;
    logic [31:0] addr;
    logic [31:0] val;
  } vec_t;

  // start, irq, done, err, reads, stores, checked address, expected word
  localparam vec_t VEC [5] = '{
    '{32'h000, 8'd1, 8'd1, 8'd0, 8'd12, 8'd2, 32'h104, 32'h12345678},
    '{32'h030, 8'd0, 8'd0, 8'd1, 8'd4,  8'd0, 32'h108, 32'h00000000},
    '{32'h040, 8'd2, 8'd1, 8'd0, 8'd12, 8'd2, 32'h10C, 32'h0000AAAA},
    '{32'h070, 8'd0, 8'd0, 8'd1, 8'd4,  8'd0, 32'h100, 32'hCAFE0001},
    '{32'h0A0, 8'd0, 8'd1, 8'd0, 8'd16, 8'd3, 32'h11C, 32'h00000066}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [31:0]   start_addr_i = '0;
  logic [SW-1:0] sync_trig_i = '0;
  logic          rd_req_o, rd_valid_i, wr_req_o, wr_ack_i;
  logic [31:0]   rd_addr_o, rd_data_i, wr_addr_o, wr_data_o;
  logic          busy_o, irq_o, done_o, err_o;

  logic [31:0] mem [0:127];
  int cyc = 0;
  int n_irq, n_done, n_err, n_rd, n_wr;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_data_i  = mem[rd_addr_o[8:2]];
  assign rd_valid_i = rd_req_o && ((cyc % 3) != 0);
  assign wr_ack_i   = wr_req_o && (cyc % 4 >= 2);

  ldchain_seq uut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .start_addr_i (start_addr_i),
    .sync_trig_i (sync_trig_i),
    .rd_req_o (rd_req_o), .rd_addr_o (rd_addr_o), .rd_valid_i (rd_valid_i), .rd_data_i (rd_data_i),
    .wr_req_o (wr_req_o), .wr_addr_o (wr_addr_o), .wr_data_o (wr_data_o), .wr_ack_i (wr_ack_i),
    .busy_o (busy_o), .irq_o (irq_o), .done_o (done_o), .err_o (err_o)
  );

  always @(negedge clk) cyc = cyc + 1;

  always @(posedge clk) begin
    if (rd_req_o && rd_valid_i) n_rd = n_rd + 1;
    if (wr_req_o && wr_ack_i) begin
      n_wr = n_wr + 1;
      mem[wr_addr_o[8:2]] = wr_data_o;
    end
    if (irq_o)  n_irq  = n_irq + 1;
    if (done_o) n_done = n_done + 1;
    if (err_o)  n_err  = n_err + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] v,
                          input logic [31:0] d, input logic [31:0] l);
    mem[a[8:2]]     = c;
    mem[a[8:2] + 1] = v;
    mem[a[8:2] + 2] = d;
    mem[a[8:2] + 3] = l;
  endtask

  task automatic clear_counts();
    n_irq = 0; n_done = 0; n_err = 0; n_rd = 0; n_wr = 0;
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk);
    start_addr_i = a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    // wait (type 1) with empty mask, absolute link 0x010
    put_desc(32'h000, 32'h1,          32'h0,        32'h0,   32'h011);
    put_desc(32'h010, 32'h0010_0002,  32'hCAFE0001, 32'h100, 32'h021);
    put_desc(32'h020, 32'h2,          32'h12345678, 32'h104, 32'h0);
    put_desc(32'h030, 32'h2,          32'hBAD,      32'h108, 32'h0);
    put_desc(32'h040, 32'h1,          32'h0,        32'h0,   32'h023);
    put_desc(32'h060, 32'h0010_0002,  32'hAAAA,     32'h10C, 32'hFFFF_FFF3);
    put_desc(32'h050, 32'h0010_0002,  32'h5555,     32'h110, 32'h0);
    put_desc(32'h070, 32'h3,          32'hDEAD,     32'h100, 32'h0);
    put_desc(32'h080, 32'h1,          32'h000F_0005, 32'h0,  32'h091);
    put_desc(32'h090, 32'h0010_0002,  32'h77,       32'h114, 32'h0);
    put_desc(32'h0A0, 32'h1,          32'h0,        32'h0,   32'h0B1);
    put_desc(32'h0B0, 32'h2,          32'h0E1,      32'h0CC, 32'h0C1);
    put_desc(32'h0C0, 32'h2,          32'h99,       32'h118, 32'h0);
    put_desc(32'h0E0, 32'h2,          32'h66,       32'h11C, 32'h0);
    clear_counts();

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy_o && !rd_req_o && !wr_req_o, "R10 reset idle", {29'd0, busy_o, rd_req_o, wr_req_o}, 32'h0);
    chk(!irq_o && !done_o && !err_o, "R7 reset pulses low", {29'd0, irq_o, done_o, err_o}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int r = 0; r < 5; r++) begin
      clear_counts();
      kick(VEC[r].start);
      chk(busy_o, "R10 busy after start", {31'd0, busy_o}, 32'h1);
      wait_idle();
      chk(!busy_o, "R10 busy low at end", {31'd0, busy_o}, 32'h0);
      chk(n_irq == int'(VEC[r].n_irq), "R3 irq count", n_irq, VEC[r].n_irq);
      chk(n_done == int'(VEC[r].n_done), "R7 done count", n_done, VEC[r].n_done);
      chk(n_err == int'(VEC[r].n_err), "R2 R9 err count", n_err, VEC[r].n_err);
      chk(n_rd == int'(VEC[r].n_rd), "R8 read count", n_rd, VEC[r].n_rd);
      chk(n_wr == int'(VEC[r].n_wr), "R1 store count", n_wr, VEC[r].n_wr);
      chk(mem[VEC[r].addr[8:2]] == VEC[r].val, "R1 R6 memory result", mem[VEC[r].addr[8:2]], VEC[r].val);
    end

    // R1 first store of chain A, R6 backward relative link of chain C
    chk(mem[32'h100 >> 2] == 32'hCAFE0001, "R1 first store", mem[32'h100 >> 2], 32'hCAFE0001);
    chk(mem[32'h110 >> 2] == 32'h5555, "R6 relative backward link", mem[32'h110 >> 2], 32'h5555);
    // R6 patched link: descriptor 0x0C0 followed its rewritten link, and its own store still ran
    chk(mem[32'h118 >> 2] == 32'h99, "R6 patched chain store", mem[32'h118 >> 2], 32'h99);

    // R4 / R5 / R10 wait descriptor: value 5, mask 0x0F
    clear_counts();
    sync_trig_i = 8'h00;
    kick(32'h080);
    repeat (20) @(negedge clk);
    chk(busy_o, "R4 held on mismatch", {31'd0, busy_o}, 32'h1);
    chk(n_rd == 4 && n_wr == 0, "R4 no progress while waiting", n_rd, 4);
    sync_trig_i = 8'h0A;
    repeat (6) @(negedge clk);
    chk(busy_o && n_rd == 4, "R4 masked mismatch still held", n_rd, 4);
    sync_trig_i = 8'h00;
    // R10 start while busy is ignored (would raise err if taken)
    kick(32'h030);
    chk(busy_o && n_rd == 4, "R10 start ignored when busy", n_rd, 4);
    // R5 one-cycle pulse, upper nibble outside the mask differs
    sync_trig_i = 8'hF5;
    @(negedge clk);
    sync_trig_i = 8'h00;
    wait_idle();
    chk(mem[32'h114 >> 2] == 32'h77, "R5 single-cycle trigger released chain", mem[32'h114 >> 2], 32'h77);
    chk(n_err == 0, "R10 ignored start made no error", n_err, 0);
    chk(n_done == 1 && n_irq == 1, "R7 R3 wait chain end", n_done, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule